// File: doc/BRIEF.md
# Cartridge Bank Register Mapper

This block holds one 8-bit control register on a retro console cartridge and turns it into the bank selection the cartridge memories need. The CPU loads the register by writing to either of two 4 KiB address windows. The register then selects three things: which 32 KiB page of a 512 KiB program memory appears at CPU 0x8000–0xFFFF, which 8 KiB pattern page of a 32 KiB video RAM the picture unit fetches from, and which 8 KiB region in the upper half of that video RAM holds the four nametables. The top two register bits drive two indicator LEDs.

Address translation is purely combinational from the register and the incoming bus addresses. Only the register is clocked. The memories, the bus timing and any programming of the program memory lie outside the block.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the control register holds 0xFF. Program page is 15, pattern page is 1, nametable page is 1, and both LEDs are lit (1).
- R2: A write strobe with cpu_addr in 0x5000–0x5FFF loads all eight bits of cpu_data into the register.
- R3: A write strobe with cpu_addr in 0x7000–0x7FFF loads all eight bits of cpu_data into the register.
- R4: A write strobe at any cpu_addr outside both windows leaves the register, and so every output, unchanged. Cycles with the strobe low have the same effect.
- R5: A qualifying write takes effect on the clock edge that samples it. Before that edge the outputs still reflect the old value.
- R6: prg_addr = {reg[3:0], cpu_addr[14:0]}. Register bits 3:0 pick one of sixteen 32 KiB pages.
- R7: When ppu_addr[13] is 0 (pattern fetch), vram_addr = reg[4]*0x2000 + ppu_addr[12:0].
- R8: When ppu_addr[13] is 1 (nametable fetch), vram_addr = 0x4000 + reg[5]*0x2000 + ppu_addr[11:0]. ppu_addr[11:10] picks one of four 1 KiB tables, and ppu_addr[12] is ignored.
- R9: led_red equals register bit 6 and led_green equals register bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 14 | Picture unit address bus |
| prg_addr | output | 19 | Program memory address |
| vram_addr | output | 15 | Video RAM address |
| led_red | output | 1 | Red indicator LED level |
| led_green | output | 1 | Green indicator LED level |

## Verification
The hardest case to reach from the ports is an ignored write that looks almost legal. This covers addresses one byte outside either window and the gap at 0x6000–0x6FFF. Such a write cannot be seen unless the data differs from the register contents. The bench therefore first loads a known value through a window. It then sweeps the stray addresses with the bitwise complement of that value, and re-reads every translated output after each stray write. The one-edge latency is checked by observing the outputs while a write is already on the bus but before its clock edge.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  localparam int DATA_W   = 8;
  localparam int PAGE_W   = 4;
  localparam int CPU_OFFW = 15;
  localparam int PPU_AW   = 14;
  localparam int VRAM_AW  = 15;
  localparam int PRG_AW   = PAGE_W + CPU_OFFW;

  typedef struct packed {
    logic              led_g;
    logic              led_r;
    logic              nt_hi;
    logic              pat_hi;
    logic [PAGE_W-1:0] prg_page;
  } ctrl_t;

  // Upper address nibble matches either decode window.
  function automatic logic win_hit(input logic [3:0] nib,
                                   input logic [3:0] win_a,
                                   input logic [3:0] win_b);
    return (nib == win_a) || (nib == win_b);
  endfunction

  function automatic logic [PRG_AW-1:0] prg_map(input ctrl_t c,
                                                input logic [CPU_OFFW-1:0] off);
    return {c.prg_page, off};
  endfunction

  // Pattern half below 0x2000, nametable region at 0x4000 + page*0x2000.
  function automatic logic [VRAM_AW-1:0] vram_map(input ctrl_t c,
                                                  input logic [PPU_AW-1:0] p);
    if (!p[13]) return {1'b0, c.pat_hi, p[12:0]};
    return {1'b1, c.nt_hi, 1'b0, p[11:0]};
  endfunction

endpackage

// File: rtl/cbm_decode.sv
module cbm_decode #(
  parameter logic [3:0] WIN_A = 4'h5,
  parameter logic [3:0] WIN_B = 4'h7
) (
  input  logic [3:0] addr_nib,
  input  logic       wr,
  output logic       hit
);
  import cbm_pkg::*;

  always_comb hit = wr && win_hit(addr_nib, WIN_A, WIN_B);

endmodule

// File: rtl/cbm_ctrl_reg.sv
module cbm_ctrl_reg #(
  parameter int         W         = 8,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RESET_VAL;
    else if (load) q <= d;
  end

endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate
  import cbm_pkg::*;
(
  input  ctrl_t                ctrl,
  input  logic [CPU_OFFW-1:0]  cpu_off,
  input  logic [PPU_AW-1:0]    ppu_addr,
  output logic [PRG_AW-1:0]    prg_addr,
  output logic [VRAM_AW-1:0]   vram_addr
);

  always_comb begin
    prg_addr  = prg_map(ctrl, cpu_off);
    vram_addr = vram_map(ctrl, ppu_addr);
  end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter logic [3:0] WIN_A = 4'h5,
  parameter logic [3:0] WIN_B = 4'h7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         cpu_addr,
  input  logic [DATA_W-1:0]   cpu_data,
  input  logic                cpu_wr,
  input  logic [PPU_AW-1:0]   ppu_addr,
  output logic [PRG_AW-1:0]   prg_addr,
  output logic [VRAM_AW-1:0]  vram_addr,
  output logic                led_red,
  output logic                led_green
);

  logic              wr_hit;   // qualifying write event
  logic [DATA_W-1:0] ctrl_q;   // latched control byte
  ctrl_t             ctrl;

  cbm_decode #(.WIN_A(WIN_A), .WIN_B(WIN_B)) u_dec (
    .addr_nib (cpu_addr[15:12]),
    .wr       (cpu_wr),
    .hit      (wr_hit)
  );

  cbm_ctrl_reg #(.W(DATA_W), .RESET_VAL({DATA_W{1'b1}})) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_hit),
    .d     (cpu_data),
    .q     (ctrl_q)
  );

  assign ctrl = ctrl_t'(ctrl_q);

  cbm_xlate u_xl (
    .ctrl      (ctrl),
    .cpu_off   (cpu_addr[CPU_OFFW-1:0]),
    .ppu_addr  (ppu_addr),
    .prg_addr  (prg_addr),
    .vram_addr (vram_addr)
  );

  assign led_red   = ctrl.led_r;
  assign led_green = ctrl.led_g;

endmodule

// File: rtl/cbm_checker.sv
module cbm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_hit,
  input logic [7:0]  ctrl_q,
  input logic [7:0]  cpu_data,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic [13:0] ppu_addr,
  input logic [18:0] prg_addr,
  input logic [14:0] vram_addr,
  input logic        led_red,
  input logic        led_green
);

  a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ctrl_q == 8'hFF);

  // R2 / R3: a qualifying write lands on the next state
  a_r2_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ctrl_q == $past(cpu_data));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] != 4'h5 && cpu_addr[15:12] != 4'h7) |=> $stable(ctrl_q));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(ctrl_q));

  a_r6_prg_page: assert property (@(posedge clk) disable iff (!rst_n)
    prg_addr[18:15] == ctrl_q[3:0] && prg_addr[14:0] == cpu_addr[14:0]);

  a_r7_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_addr[13] |-> (vram_addr[14] == 1'b0 && vram_addr[13] == ctrl_q[4]));

  a_r8_nametable: assert property (@(posedge clk) disable iff (!rst_n)
    ppu_addr[13] |-> (vram_addr[14] && !vram_addr[12] && vram_addr[13] == ctrl_q[5]
                      && vram_addr[11:0] == ppu_addr[11:0]));

  a_r9_leds: assert property (@(posedge clk) disable iff (!rst_n)
    led_red == ctrl_q[6] && led_green == ctrl_q[7]);

endmodule

bind cart_bank_mapper cbm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_hit    (wr_hit),
  .ctrl_q    (ctrl_q),
  .cpu_data  (cpu_data),
  .cpu_addr  (cpu_addr),
  .cpu_wr    (cpu_wr),
  .ppu_addr  (ppu_addr),
  .prg_addr  (prg_addr),
  .vram_addr (vram_addr),
  .led_red   (led_red),
  .led_green (led_green)
);

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = 14'h0000;
  logic [18:0] prg_addr;
  logic [14:0] vram_addr;
  logic        led_red, led_green;

  int n_tests = 0;
  int n_fail  = 0;
  int model;          // expected register contents
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
    .vram_addr(vram_addr), .led_red(led_red), .led_green(led_green)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Compare every translated output with arithmetic on the model value.
  task automatic check_outputs(input int r, input int sel);
    int bank = r % 16;
    int pat  = (r / 16) % 2;
    int nt   = (r / 32) % 2;
    int cpu_sample = ((sel * 7919) % 32768) + 32768;
    cpu_addr = 16'(cpu_sample);
    cpu_wr = 1'b0;
    for (int t = 0; t < 16; t++) begin
      int p = t * 1024 + ((sel * 37 + t * 11) % 1024);
      ppu_addr = 14'(p);
      #1;
      if (p < 8192) check("R7", int'(vram_addr), pat * 8192 + p);
      else          check("R8", int'(vram_addr), 16384 + nt * 8192 + (p % 4096));
    end
    check("R6", int'(prg_addr), bank * 32768 + (cpu_sample - 32768));
    check("R9 red",   int'(led_red),   (r / 64) % 2);
    check("R9 green", int'(led_green), r / 128);
  endtask

  task automatic bus_write(input int a, input int d, input string req);
    @(negedge clk);
    cpu_addr = 16'(a);
    cpu_data = 8'(d);
    cpu_wr   = 1'b1;
    #1;
    // R5: before the edge the old contents still drive the outputs
    check({req, " R5 pre-edge"}, int'(prg_addr[18:15]), model % 16);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    model = 255;
    check_outputs(model, 1);            // R1 reset value (0xFF)
    check("R1", int'(prg_addr[18:15]), 15);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs(model, 2);

    // R2 / R3: every byte through alternating windows, varied offsets
    for (int d = 0; d < 256; d++) begin
      int base = (d % 2 == 0) ? 20480 : 28672;
      int off  = (d * 613) % 4096;
      bus_write(base + off, d, (d % 2 == 0) ? "R2" : "R3");
      model = d;
      check((d % 2 == 0) ? "R2 load" : "R3 load", int'({led_green, led_red}), d / 64);
      check_outputs(model, d);
    end

    // Window edges are accepted
    bus_write(16'h5000, 8'h3A, "R2"); model = 58; check_outputs(model, 3);
    bus_write(16'h5FFF, 8'hC5, "R2"); model = 197; check_outputs(model, 4);
    bus_write(16'h7000, 8'h6B, "R3"); model = 107; check_outputs(model, 5);
    bus_write(16'h7FFF, 8'h94, "R3"); model = 148; check_outputs(model, 6);

    // R4: stray writes with complemented data at every 256-byte step
    for (int k = 0; k < 256; k++) begin
      int a = k * 256 + ((k % 2) ? 255 : 0);
      if ((a / 4096) == 5 || (a / 4096) == 7) continue;
      bus_write(a, 255 - model, "R4");
      check_outputs(model, k);
    end
    // R4: addresses adjacent to each window
    bus_write(16'h4FFF, 8'h6B, "R4"); check_outputs(model, 7);
    bus_write(16'h6000, 8'h6B, "R4"); check_outputs(model, 8);
    bus_write(16'h6FFF, 8'h6B, "R4"); check_outputs(model, 9);
    bus_write(16'h8000, 8'h6B, "R4"); check_outputs(model, 10);

    // R4: data on a window address with the strobe low does nothing
    @(negedge clk);
    cpu_addr = 16'h5123; cpu_data = 8'h00; cpu_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_outputs(model, 11);

    // R5: the change is visible one edge after the write
    bus_write(16'h7ABC, 8'h0F, "R5");
    model = 15;
    check("R5 post-edge", int'(prg_addr[18:15]), 15);
    check_outputs(model, 12);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule